// File: doc/BRIEF.md
# I2C Master Register Front-End

This block sits between a byte-wide register port and a transaction-level I2C bus engine. It holds eighteen one-byte registers. The addresses, control, mode, status, extended status, clock divider, interrupt mask, transfer count, extended control, direct control, interrupt and slave fields are all reached through a 5-bit offset. Some register accesses also drive the bus. A write to the data register opens a write transaction if none is active and then sends the byte. A write to control with the transfer and read bits set opens a read transaction. A read of the data register pulls the next received byte. While it does so it counts down a two-bit count of further bytes kept in the control register, and it restarts the read while that count is nonzero.

The engine takes four requests: start (7-bit address plus direction), send byte, receive byte and stop. Each returns an ack or nack. A register access that needs the engine holds off `reg_ready` until all of its engine requests have completed. Every access ends with exactly one `reg_ready` pulse, which carries the read data. A stop is only requested while a transaction is open.

Top module: `i2cm_regfront`

## Requirements
- R1: After reset, extended status (offset 9) reads 0x8F, direct control (offset 16) reads 0x0F, and every other register reads 0. The data register (offset 0) reads 0xFF because no receive data is pending.
- R2: Offsets 1 and 3 and every offset from 18 upward read as 0, and writes to them change nothing.
- R3: Stored write values are masked as follows: mode control (offset 7) keeps value & 0xDF, transfer count (offset 14) keeps value & 0x77, and direct control (offset 16) keeps value & 0x07. The slave data, high address, slave addresses, clock divider, interrupt mask and interrupt registers (offsets 2, 5, 10, 11, 12, 13, 17) store the value as written.
- R4: A write to status (offset 8) clears only the bits that are set in value & 0x0A. A write to extended status (offset 9) clears the bits that are set in value & 0x8F.
- R5: Writing data (offset 0) with no open transaction requests a write-direction start to the address in bits 7:1 of offset 4. On ack it sets status bit0 (transfer pending), clears status bit2 (error) and zeroes extended status. Whenever a transaction is then open, the byte is sent.
- R6: A nack on a sent data byte clears status bit0, sets status bit2, sets extended status bit0 (abort) and requests a stop.
- R7: A nack on any start clears status bit0, sets status bit2 and sets extended status bit0. No data byte is sent after it.
- R8: A control (offset 6) write with bit0=1 and bit1=1 first stops any open transaction, clearing status bit0, and then requests a read-direction start. On ack this sets status bit5 (receive data pending), clears status bit2 and zeroes extended status. A control write with bit0=1 and bit1=0 only clears status bit0. The written value is stored in control.
- R9: Reading data while status bit5 is 0 returns 0xFF with no bus request. Otherwise the block receives a byte and returns it, or returns 0xFF if the receive fails.
- R10: On a data read with status bit5 set, control bits 5:4 are decremented, with 0 wrapping to 3. If they were 0, status bit5 is cleared. If they were nonzero, the block stops the open transaction and requests a new read start, with the flag handling of R7/R8.
- R11: Writing offset 4 stops an open transaction. No stop is ever requested without an open transaction.
- R12: Writing extended control (offset 15) with bit0 set returns all registers to their R1 values, and the value is not stored. Otherwise the value is stored as written.
- R13: Each access gives exactly one single-cycle `reg_ready` pulse. The pulse never coincides with an outstanding engine request. An engine request holds its fields until `eng_done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 1 | Access request, held until `reg_ready` |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 8 | Write value |
| reg_rdata | output | 8 | Read value, valid with `reg_ready` |
| reg_ready | output | 1 | One-cycle access completion |
| eng_req | output | 1 | Engine request outstanding |
| eng_op | output | 2 | 0 start, 1 send, 2 receive, 3 stop |
| eng_addr | output | 7 | Start target address |
| eng_rnw | output | 1 | Start direction, 1 = read |
| eng_wdata | output | 8 | Byte to send |
| eng_done | input | 1 | One-cycle engine completion |
| eng_ack | input | 1 | Completion result, 1 = ack |
| eng_rdata | input | 8 | Received byte |

## Verification
A behavioural target with a fixed 7-bit address acks matching starts and nacks the data byte 0xEE. Receives can be made to fail on demand. Writes are tried first to the matching address and then to a wrong one, which separates the start-nack path from the data-nack path and shows that no byte follows a refused address. Reads are run with pending counts of 2, 1 and 0, with a failed receive, and with no receive data pending, which tells the restart path from the final-byte path and exposes the wrap to 3. The engine request counters show that a stop is requested only on open transactions. Mask and soft-reset patterns of all ones separate the masked registers from the plain ones.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  localparam int REG_AW   = 5;
  localparam int DW       = 8;
  localparam int NUM_REGS = 18;
  localparam int BUS_AW   = 7;

  localparam logic [REG_AW-1:0] OFF_MDATA  = 5'd0;
  localparam logic [REG_AW-1:0] OFF_SDATA  = 5'd2;
  localparam logic [REG_AW-1:0] OFF_LADR   = 5'd4;
  localparam logic [REG_AW-1:0] OFF_HADR   = 5'd5;
  localparam logic [REG_AW-1:0] OFF_CTRL   = 5'd6;
  localparam logic [REG_AW-1:0] OFF_MODE   = 5'd7;
  localparam logic [REG_AW-1:0] OFF_STAT   = 5'd8;
  localparam logic [REG_AW-1:0] OFF_XSTAT  = 5'd9;
  localparam logic [REG_AW-1:0] OFF_SLADR  = 5'd10;
  localparam logic [REG_AW-1:0] OFF_SHADR  = 5'd11;
  localparam logic [REG_AW-1:0] OFF_CDIV   = 5'd12;
  localparam logic [REG_AW-1:0] OFF_IMASK  = 5'd13;
  localparam logic [REG_AW-1:0] OFF_COUNT  = 5'd14;
  localparam logic [REG_AW-1:0] OFF_XCTL   = 5'd15;
  localparam logic [REG_AW-1:0] OFF_DIRECT = 5'd16;
  localparam logic [REG_AW-1:0] OFF_INTR   = 5'd17;

  localparam int CT_PT   = 0;
  localparam int CT_RD   = 1;
  localparam int SB_PT   = 0;
  localparam int SB_ERR  = 2;
  localparam int SB_MDBS = 5;
  localparam int XB_ABRT = 0;

  localparam logic [DW-1:0] STAT_W1C  = 8'h0A;
  localparam logic [DW-1:0] XSTAT_W1C = 8'h8F;
  localparam logic [DW-1:0] MODE_MASK = 8'hDF;
  localparam logic [DW-1:0] CNT_MASK  = 8'h77;
  localparam logic [DW-1:0] DIR_MASK  = 8'h07;
  localparam logic [DW-1:0] NO_DATA   = 8'hFF;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_SEND  = 2'd1,
    OP_RECV  = 2'd2,
    OP_STOP  = 2'd3
  } bus_op_t;

  typedef enum logic [3:0] {
    SQ_IDLE, SQ_WSTART, SQ_SEND, SQ_SSTOP, SQ_ASTOP,
    SQ_CSTOP, SQ_RSTART, SQ_RECV, SQ_RSTOP
  } seq_t;

  function automatic logic [DW-1:0] reset_val(input int idx);
    if (idx == int'(OFF_XSTAT))       return 8'h8F;
    else if (idx == int'(OFF_DIRECT)) return 8'h0F;
    else                              return '0;
  endfunction
endpackage

// File: rtl/i2cm_readmux.sv
module i2cm_readmux
  import i2cm_pkg::*;
(
  input  logic [NUM_REGS-1:0][DW-1:0] rf,
  input  logic [REG_AW-1:0]           addr,
  output logic [DW-1:0]               q
);
  localparam logic [REG_AW-1:0] LAST = REG_AW'(NUM_REGS - 1);

  always_comb begin
    q = '0;
    if (addr <= LAST && addr != 5'd1 && addr != 5'd3)
      q = rf[addr];
  end
endmodule

// File: rtl/i2cm_wmask.sv
module i2cm_wmask
  import i2cm_pkg::*;
(
  input  logic [REG_AW-1:0] addr,
  input  logic [DW-1:0]     wdata,
  input  logic [DW-1:0]     stat,
  input  logic [DW-1:0]     xstat,
  output logic              st_en,
  output logic [DW-1:0]     st_val
);
  always_comb begin
    st_en  = 1'b1;
    st_val = wdata;
    case (addr)
      OFF_SDATA, OFF_HADR, OFF_SLADR, OFF_SHADR,
      OFF_CDIV, OFF_IMASK, OFF_INTR: st_val = wdata;
      OFF_MODE:   st_val = wdata & MODE_MASK;
      OFF_COUNT:  st_val = wdata & CNT_MASK;
      OFF_DIRECT: st_val = wdata & DIR_MASK;
      OFF_STAT:   st_val = stat & ~(wdata & STAT_W1C);
      OFF_XSTAT:  st_val = xstat & ~(wdata & XSTAT_W1C);
      default:    st_en  = 1'b0;
    endcase
  end
endmodule

// File: rtl/i2cm_regfront.sv
module i2cm_regfront
  import i2cm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_sel,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic              reg_ready,
  output logic              eng_req,
  output logic [1:0]        eng_op,
  output logic [BUS_AW-1:0] eng_addr,
  output logic              eng_rnw,
  output logic [DW-1:0]     eng_wdata,
  input  logic              eng_done,
  input  logic              eng_ack,
  input  logic [DW-1:0]     eng_rdata
);
  logic [NUM_REGS-1:0][DW-1:0] rf;
  seq_t    state;
  logic    active;
  logic    ready_q;
  logic [DW-1:0] rdata_q;
  logic    req_q;
  bus_op_t op_q;
  logic [BUS_AW-1:0] addr_q;
  logic    rnw_q;
  logic [DW-1:0] wd_q;

  logic [DW-1:0] stat_w, xstat_w, ctrl_w, mux_q, st_val;
  logic          st_en, mdbs;

  assign stat_w  = rf[OFF_STAT];
  assign xstat_w = rf[OFF_XSTAT];
  assign ctrl_w  = rf[OFF_CTRL];
  assign mdbs    = stat_w[SB_MDBS];

  i2cm_readmux u_rmux (.rf(rf), .addr(reg_addr), .q(mux_q));

  i2cm_wmask u_wmask (
    .addr(reg_addr), .wdata(reg_wdata), .stat(stat_w), .xstat(xstat_w),
    .st_en(st_en), .st_val(st_val)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= SQ_IDLE;
      active  <= 1'b0;
      ready_q <= 1'b0;
      rdata_q <= '0;
      req_q   <= 1'b0;
      op_q    <= OP_START;
      addr_q  <= '0;
      rnw_q   <= 1'b0;
      wd_q    <= '0;
      for (int i = 0; i < NUM_REGS; i++) rf[i] <= reset_val(i);
    end else begin
      ready_q <= 1'b0;
      if (eng_done) req_q <= 1'b0;
      case (state)
        SQ_IDLE: begin
          if (reg_sel && !ready_q) begin
            if (reg_we) begin
              if (st_en) rf[reg_addr] <= st_val;
              case (reg_addr)
                OFF_MDATA: begin
                  rf[OFF_MDATA] <= reg_wdata;
                  wd_q  <= reg_wdata;
                  req_q <= 1'b1;
                  if (!active) begin
                    op_q   <= OP_START;
                    rnw_q  <= 1'b0;
                    addr_q <= rf[OFF_LADR][7:1];
                    state  <= SQ_WSTART;
                  end else begin
                    op_q  <= OP_SEND;
                    state <= SQ_SEND;
                  end
                end
                OFF_LADR: begin
                  rf[OFF_LADR] <= reg_wdata;
                  if (active) begin
                    req_q <= 1'b1;
                    op_q  <= OP_STOP;
                    state <= SQ_ASTOP;
                  end else begin
                    ready_q <= 1'b1;
                  end
                end
                OFF_CTRL: begin
                  rf[OFF_CTRL] <= reg_wdata;
                  if (reg_wdata[CT_PT] && reg_wdata[CT_RD]) begin
                    req_q <= 1'b1;
                    if (active) begin
                      rf[OFF_STAT][SB_PT] <= 1'b0;
                      op_q  <= OP_STOP;
                      state <= SQ_CSTOP;
                    end else begin
                      op_q   <= OP_START;
                      rnw_q  <= 1'b1;
                      addr_q <= rf[OFF_LADR][7:1];
                      state  <= SQ_RSTART;
                    end
                  end else begin
                    if (reg_wdata[CT_PT]) rf[OFF_STAT][SB_PT] <= 1'b0;
                    ready_q <= 1'b1;
                  end
                end
                OFF_XCTL: begin
                  if (reg_wdata[0]) begin
                    for (int i = 0; i < NUM_REGS; i++) rf[i] <= reset_val(i);
                  end else begin
                    rf[OFF_XCTL] <= reg_wdata;
                  end
                  ready_q <= 1'b1;
                end
                default: ready_q <= 1'b1;
              endcase
            end else begin
              if (reg_addr == OFF_MDATA) begin
                if (!mdbs) begin
                  rdata_q <= NO_DATA;
                  ready_q <= 1'b1;
                end else begin
                  req_q <= 1'b1;
                  op_q  <= OP_RECV;
                  state <= SQ_RECV;
                end
              end else begin
                rdata_q <= mux_q;
                ready_q <= 1'b1;
              end
            end
          end
        end
        SQ_WSTART: if (eng_done) begin
          if (eng_ack) begin
            active <= 1'b1;
            rf[OFF_STAT][SB_PT]  <= 1'b1;
            rf[OFF_STAT][SB_ERR] <= 1'b0;
            rf[OFF_XSTAT] <= '0;
            req_q <= 1'b1;
            op_q  <= OP_SEND;
            state <= SQ_SEND;
          end else begin
            rf[OFF_STAT][SB_PT]     <= 1'b0;
            rf[OFF_STAT][SB_ERR]    <= 1'b1;
            rf[OFF_XSTAT][XB_ABRT]  <= 1'b1;
            ready_q <= 1'b1;
            state   <= SQ_IDLE;
          end
        end
        SQ_SEND: if (eng_done) begin
          if (eng_ack) begin
            ready_q <= 1'b1;
            state   <= SQ_IDLE;
          end else begin
            rf[OFF_STAT][SB_PT]    <= 1'b0;
            rf[OFF_STAT][SB_ERR]   <= 1'b1;
            rf[OFF_XSTAT][XB_ABRT] <= 1'b1;
            req_q <= 1'b1;
            op_q  <= OP_STOP;
            state <= SQ_SSTOP;
          end
        end
        SQ_SSTOP, SQ_ASTOP: if (eng_done) begin
          active  <= 1'b0;
          ready_q <= 1'b1;
          state   <= SQ_IDLE;
        end
        SQ_CSTOP, SQ_RSTOP: if (eng_done) begin
          active <= 1'b0;
          req_q  <= 1'b1;
          op_q   <= OP_START;
          rnw_q  <= 1'b1;
          addr_q <= rf[OFF_LADR][7:1];
          state  <= SQ_RSTART;
        end
        SQ_RSTART: if (eng_done) begin
          if (eng_ack) begin
            active <= 1'b1;
            rf[OFF_STAT][SB_MDBS] <= 1'b1;
            rf[OFF_STAT][SB_ERR]  <= 1'b0;
            rf[OFF_XSTAT] <= '0;
          end else begin
            rf[OFF_STAT][SB_PT]    <= 1'b0;
            rf[OFF_STAT][SB_ERR]   <= 1'b1;
            rf[OFF_XSTAT][XB_ABRT] <= 1'b1;
          end
          ready_q <= 1'b1;
          state   <= SQ_IDLE;
        end
        SQ_RECV: if (eng_done) begin
          rdata_q <= eng_ack ? eng_rdata : NO_DATA;
          rf[OFF_CTRL][5:4] <= ctrl_w[5:4] - 2'd1;
          if (ctrl_w[5:4] == 2'd0) begin
            rf[OFF_STAT][SB_MDBS] <= 1'b0;
            ready_q <= 1'b1;
            state   <= SQ_IDLE;
          end else if (active) begin
            req_q <= 1'b1;
            op_q  <= OP_STOP;
            state <= SQ_RSTOP;
          end else begin
            req_q  <= 1'b1;
            op_q   <= OP_START;
            rnw_q  <= 1'b1;
            addr_q <= rf[OFF_LADR][7:1];
            state  <= SQ_RSTART;
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  assign reg_rdata = rdata_q;
  assign reg_ready = ready_q;
  assign eng_req   = req_q;
  assign eng_op    = op_q;
  assign eng_addr  = addr_q;
  assign eng_rnw   = rnw_q;
  assign eng_wdata = wd_q;
endmodule

// File: rtl/i2cm_regfront_chk.sv
module i2cm_regfront_chk
  import i2cm_pkg::*;
(
  input logic          clk,
  input logic          rst,
  input logic          reg_ready,
  input logic          eng_req,
  input logic [1:0]    eng_op,
  input logic          eng_done,
  input logic          active,
  input logic [DW-1:0] stat,
  input logic [DW-1:0] xstat
);
  assert_stop_active_R11: assert property (@(posedge clk) disable iff (rst)
    (eng_req && eng_op == OP_STOP) |-> active);

  assert_ready_pulse_R13: assert property (@(posedge clk) disable iff (rst)
    reg_ready |=> !reg_ready);

  assert_ready_no_req_R13: assert property (@(posedge clk) disable iff (rst)
    reg_ready |-> !eng_req);

  assert_req_hold_R13: assert property (@(posedge clk) disable iff (rst)
    (eng_req && !eng_done) |=> (eng_req && $stable(eng_op)));

  assert_err_flags_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(stat[SB_ERR]) |-> (!stat[SB_PT] && xstat[XB_ABRT]));

  assert_mdbs_flags_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(stat[SB_MDBS]) |-> (!stat[SB_ERR] && xstat == '0));
endmodule

bind i2cm_regfront i2cm_regfront_chk u_chk (
  .clk(clk), .rst(rst), .reg_ready(reg_ready), .eng_req(eng_req),
  .eng_op(eng_op), .eng_done(eng_done), .active(active),
  .stat(stat_w), .xstat(xstat_w)
);

// File: tb/test_i2cm_regfront.sv
module test_i2cm_regfront;
  import i2cm_pkg::*;

  localparam logic [6:0] TGT = 7'h50;
  localparam logic [7:0] NACK_BYTE = 8'hEE;

  logic clk = 0, rst = 1;
  logic reg_sel = 0, reg_we = 0;
  logic [4:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic reg_ready, eng_req, eng_rnw, eng_done = 0, eng_ack = 0;
  logic [1:0] eng_op;
  logic [6:0] eng_addr;
  logic [7:0] eng_wdata, eng_rdata = 0;

  int checks = 0, errors = 0, cycles = 0;
  int n_start = 0, n_send = 0, n_recv = 0, n_stop = 0;
  logic [6:0] last_addr = 0;
  logic last_rnw = 0;
  logic [7:0] last_sent = 0, rx_next = 8'hC0;
  bit mdl_active = 0, fail_rx = 0, m_busy = 0;
  int m_cnt = 0;
  logic [1:0] m_op = 0;
  logic [6:0] m_addr = 0;
  logic [7:0] m_wd = 0;

  always #10 clk = ~clk;

  i2cm_regfront i_i2cm_regfront (.*);

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  // target model on the engine side
  always @(posedge clk) begin
    eng_done <= 1'b0;
    if (rst) begin
      m_busy = 0; mdl_active = 0;
    end else if (m_busy) begin
      if (m_cnt != 0) m_cnt = m_cnt - 1;
      else begin
        m_busy = 0;
        eng_done <= 1'b1;
        case (m_op)
          2'd0: begin
            n_start++; last_addr = m_addr;
            eng_ack <= (m_addr == TGT);
            mdl_active = (m_addr == TGT);
          end
          2'd1: begin
            n_send++; last_sent = m_wd;
            eng_ack <= mdl_active && (m_wd != NACK_BYTE);
          end
          2'd2: begin
            n_recv++;
            if (mdl_active && !fail_rx) begin
              eng_ack <= 1'b1; eng_rdata <= rx_next; rx_next = rx_next + 1;
            end else begin
              eng_ack <= 1'b0; eng_rdata <= 8'h00;
            end
          end
          default: begin n_stop++; mdl_active = 0; eng_ack <= 1'b1; end
        endcase
      end
    end else if (eng_req && !eng_done) begin
      m_busy = 1; m_cnt = 2; m_op = eng_op; m_addr = eng_addr; m_wd = eng_wdata;
      if (eng_op == 2'd0) last_rnw = eng_rnw;
      if (eng_op == 2'd3) begin
        checks++;
        if (!mdl_active) begin
          errors++;
          $display("FAIL R11: stop requested with no open transaction got 1 expected 0");
        end
      end
    end
  end

  // per-clock monitor: ready never overlaps an outstanding request
  always @(negedge clk) begin
    if (!rst && reg_ready) chk("R13 ready with request", eng_req, 0);
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic acc(input bit wr, input logic [4:0] a, input logic [7:0] d, output logic [7:0] q);
    @(negedge clk);
    reg_sel = 1; reg_we = wr; reg_addr = a; reg_wdata = d;
    do @(negedge clk); while (!reg_ready);
    q = reg_rdata;
    reg_sel = 0;
    @(negedge clk);
    chk("R13 single ready pulse", reg_ready, 0);
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    logic [7:0] q;
    acc(1, a, d, q);
  endtask

  task automatic rd(input string tag, input logic [4:0] a, input logic [7:0] e);
    logic [7:0] q;
    acc(0, a, 8'h00, q);
    chk(tag, q, e);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 ready at reset", reg_ready, 0);
    for (int i = 1; i < 18; i++)
      rd("R1 reset value", 5'(i), (i == 9) ? 8'h8F : (i == 16) ? 8'h0F : 8'h00);
    rd("R1 data with nothing pending", 5'd0, 8'hFF);
    chk("R9 no receive at reset", n_recv, 0);
    // R2 holes and out of range
    wr(5'd1, 8'h55); wr(5'd3, 8'hAA); wr(5'd20, 8'h77);
    rd("R2 offset 1", 5'd1, 8'h00);
    rd("R2 offset 3", 5'd3, 8'h00);
    rd("R2 offset 20", 5'd20, 8'h00);
    rd("R2 offset 31", 5'd31, 8'h00);
    // R5 write transaction
    wr(OFF_LADR, 8'hA0);
    chk("R11 no stop when idle", n_stop, 0);
    wr(OFF_MDATA, 8'h12);
    chk("R5 one start", n_start, 1);
    chk("R5 start address", last_addr, 7'h50);
    chk("R5 start direction", last_rnw, 0);
    chk("R5 byte sent", last_sent, 8'h12);
    rd("R5 status after ack", OFF_STAT, 8'h01);
    rd("R5 xstatus after ack", OFF_XSTAT, 8'h00);
    wr(OFF_MDATA, 8'h34);
    chk("R5 no second start", n_start, 1);
    chk("R5 second byte", n_send, 2);
    // R6 data nack
    wr(OFF_MDATA, NACK_BYTE);
    chk("R6 stop after nack", n_stop, 1);
    rd("R6 status", OFF_STAT, 8'h04);
    rd("R6 xstatus", OFF_XSTAT, 8'h01);
    // R4 write-one-to-clear
    wr(OFF_STAT, 8'hFF);
    rd("R4 status keeps error", OFF_STAT, 8'h04);
    wr(OFF_XSTAT, 8'h0E);
    rd("R4 xstatus unmasked bit kept", OFF_XSTAT, 8'h01);
    wr(OFF_XSTAT, 8'h01);
    rd("R4 xstatus cleared", OFF_XSTAT, 8'h00);
    // R7 address nack on write
    wr(OFF_LADR, 8'h20);
    wr(OFF_MDATA, 8'h33);
    chk("R7 start issued", n_start, 2);
    chk("R7 start address", last_addr, 7'h10);
    chk("R7 no byte sent", n_send, 3);
    rd("R7 status", OFF_STAT, 8'h04);
    rd("R7 xstatus", OFF_XSTAT, 8'h01);
    // R8 read start
    wr(OFF_LADR, 8'hA0);
    chk("R11 no stop after refused start", n_stop, 1);
    wr(OFF_CTRL, 8'h23);
    chk("R8 read start", n_start, 3);
    chk("R8 read direction", last_rnw, 1);
    chk("R8 no stop when idle", n_stop, 1);
    rd("R8 status", OFF_STAT, 8'h20);
    rd("R8 xstatus", OFF_XSTAT, 8'h00);
    rd("R8 control stored", OFF_CTRL, 8'h23);
    // R10 pending count
    rd("R9 first byte", OFF_MDATA, 8'hC0);
    chk("R10 restart stop", n_stop, 2);
    chk("R10 restart start", n_start, 4);
    rd("R10 count 2 to 1", OFF_CTRL, 8'h13);
    rd("R9 second byte", OFF_MDATA, 8'hC1);
    chk("R10 second restart", n_start, 5);
    rd("R10 count 1 to 0", OFF_CTRL, 8'h03);
    rd("R9 third byte", OFF_MDATA, 8'hC2);
    chk("R10 no stop on last", n_stop, 3);
    rd("R10 wrap to 3", OFF_CTRL, 8'h33);
    rd("R10 status cleared", OFF_STAT, 8'h00);
    rd("R9 no data pending", OFF_MDATA, 8'hFF);
    chk("R9 no receive without data", n_recv, 3);
    // R8 control read with open transaction
    wr(OFF_CTRL, 8'h03);
    chk("R8 stop before restart", n_stop, 4);
    chk("R8 restart", n_start, 6);
    rd("R8 status again", OFF_STAT, 8'h20);
    fail_rx = 1;
    rd("R9 failed receive", OFF_MDATA, 8'hFF);
    fail_rx = 0;
    chk("R9 receive attempted", n_recv, 4);
    rd("R10 status after failed last", OFF_STAT, 8'h00);
    rd("R10 wrap after failed", OFF_CTRL, 8'h33);
    // R11 address write stops
    wr(OFF_LADR, 8'hA0);
    chk("R11 stop on address write", n_stop, 5);
    wr(OFF_MDATA, 8'h44);
    rd("R5 status pending", OFF_STAT, 8'h01);
    wr(OFF_CTRL, 8'h01);
    rd("R8 pending cleared", OFF_STAT, 8'h00);
    chk("R8 no start for write control", n_start, 7);
    rd("R8 control value", OFF_CTRL, 8'h01);
    // R7 read start nack
    wr(OFF_LADR, 8'h22);
    chk("R11 stop", n_stop, 6);
    wr(OFF_CTRL, 8'h03);
    chk("R7 read start", n_start, 8);
    rd("R7 read nack status", OFF_STAT, 8'h04);
    rd("R7 read nack xstatus", OFF_XSTAT, 8'h01);
    // R3 masks
    wr(OFF_MODE, 8'hFF);   rd("R3 mode", OFF_MODE, 8'hDF);
    wr(OFF_COUNT, 8'hFF);  rd("R3 count", OFF_COUNT, 8'h77);
    wr(OFF_DIRECT, 8'hFF); rd("R3 direct", OFF_DIRECT, 8'h07);
    wr(OFF_CDIV, 8'hAB);   rd("R3 divider", OFF_CDIV, 8'hAB);
    wr(OFF_INTR, 8'h5A);   rd("R3 interrupt", OFF_INTR, 8'h5A);
    wr(OFF_SDATA, 8'h3C);  rd("R3 slave data", OFF_SDATA, 8'h3C);
    wr(OFF_HADR, 8'h11);   rd("R3 high address", OFF_HADR, 8'h11);
    // R12 soft reset
    wr(OFF_XCTL, 8'h02);
    rd("R12 stored without reset", OFF_XCTL, 8'h02);
    wr(OFF_XCTL, 8'h81);
    for (int i = 1; i < 18; i++)
      rd("R12 soft reset value", 5'(i), (i == 9) ? 8'h8F : (i == 16) ? 8'h0F : 8'h00);
    rd("R12 data after soft reset", OFF_MDATA, 8'hFF);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule